// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Control

This block is the clocked front end of a single-port burst SRAM. On each rising clock edge it takes the address, three chip enables, two address strobes, a burst-advance input and the write controls. From these it picks the kind of cycle: deselect, start of a burst, next beat of a burst, or a repeat of the current beat. It then forms the array address, writes the chosen byte lanes or reads a word, and reports what it did.

A burst begins at an address taken from the address input. After that, the two low address bits come from a 2-bit burst counter, and the upper bits stay fixed. The counter steps either by adding one or by XOR-ing its step count into the start value, as a mode input chooses. There are two strobes with different rules. The processor strobe is masked by the first enable and always starts a read. The controller strobe starts a read or a write, depending on the decoded write controls. The storage behind the block is a small array of byte lanes.

Top module: `sbsram_ctrl`

## Requirements
- R1: While reset is active and just after it, `acc_valid`, `rd_valid`, `rdata` and `acc_addr` are all zero.
- R2: The part is enabled only when `en2` is 1 and both `en1_n` and `en3_n` are 0. A strobe accepted while the part is not enabled gives a deselect cycle, which shows `acc_valid`=0. Cycles with both strobes high that follow a deselect make no access until a new burst starts.
- R3: While `en1_n` is 1, `ads_cpu_n` is ignored. If the part is idle, nothing happens. If a burst is in progress and `ads_ctl_n` is 1, the burst carries on as set by `adv_n`.
- R4: A processor-strobe start (`ads_cpu_n`=0, `en1_n`=0, part enabled) always reads from `addr_i`, even when the write controls ask for a write. The array is left unchanged.
- R5: A controller-strobe start (`ads_ctl_n`=0 with `ads_cpu_n`=1, part enabled) reads or writes at `addr_i`, as the write decode decides.
- R6: When both strobes are 1, `adv_n` is 0 and a burst is active, the access uses the next burst-counter address. The read or write follows the write decode.
- R7: When both strobes are 1, `adv_n` is 1 and a burst is active, the access uses the same address again.
- R8: With `order_il`=0 (linear), the low two address bits are the start value plus the beat count, modulo 4. The upper bits are held. The fifth access returns to the start address.
- R9: With `order_il`=1 (interleaved), the low two bits are the start value XOR the beat count. The beat count runs 0, 1, 2, 3 and then back to 0.
- R10: `gwr_n`=0 writes every byte lane, whatever `bwr_n` and `lane_n` say.
- R11: With `gwr_n`=1 and `bwr_n`=0, only the lanes whose `lane_n` bit is 0 are written. Lane i holds data bits [8i+7:8i]. If all `lane_n` bits are 1, nothing is written. With `gwr_n`=1 and `bwr_n`=1, the cycle is a read.
- R12: All outputs change at the clock edge that samples the cycle's inputs. A write stores its data at that edge, so a read in a later cycle returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | External word address |
| en1_n | input | 1 | Chip enable, active low; also masks the processor strobe |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| ads_cpu_n | input | 1 | Processor address strobe, active low |
| ads_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Write all lanes, active low |
| bwr_n | input | 1 | Byte-write qualifier, active low |
| lane_n | input | DW/8 | Per-lane write selects, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata | input | DW | Write data |
| rdata | output | DW | Data from the last read access |
| rd_valid | output | 1 | The cycle just registered was a read |
| acc_valid | output | 1 | The cycle just registered touched the array |
| acc_addr | output | AW | Array address used by that cycle |

## Verification
The bench starts bursts at start values that are not aligned, in both linear and interleaved order, and runs five beats. This tells the two counting rules apart and shows the wrap back to the start address. Beats held by `adv_n` are mixed in between advancing beats to show that a held beat keeps the address and the counter. Writes using the global control, the per-lane control with one lane selected, and the per-lane control with no lane selected are read back to tell each decode path apart. Processor-strobe starts with writes requested, strobes given while the part is disabled, and strobes masked by the first enable are checked to separate the two strobe rules.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [2:0] {
    CYC_NONE  = 3'd0,
    CYC_DESEL = 3'd1,
    CYC_LOAD  = 3'd2,
    CYC_NEXT  = 3'd3,
    CYC_HOLD  = 3'd4
  } cyc_e;

  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic       il);
    return il ? (base ^ step) : (base + step);
  endfunction
endpackage

// File: rtl/sbsram_cycle_dec.sv
module sbsram_cycle_dec
  import sbsram_pkg::*;
(
  input  logic en1_n,
  input  logic en2,
  input  logic en3_n,
  input  logic ads_cpu_n,
  input  logic ads_ctl_n,
  input  logic adv_n,
  input  logic sel_q,
  input  logic wr_req,
  output cyc_e cyc,
  output logic is_wr,
  output logic from_cpu
);
  logic en_ok;
  logic cpu_go;
  logic ctl_go;

  always_comb begin
    en_ok    = en2 & ~en1_n & ~en3_n;
    cpu_go   = ~ads_cpu_n & ~en1_n;
    ctl_go   = ~ads_ctl_n & ~cpu_go;
    from_cpu = cpu_go;
    cyc      = CYC_NONE;
    is_wr    = 1'b0;
    if (cpu_go || ctl_go) begin
      if (en_ok) begin
        cyc   = CYC_LOAD;
        is_wr = ctl_go & wr_req;
      end else begin
        cyc   = CYC_DESEL;
      end
    end else if (sel_q) begin
      cyc   = adv_n ? CYC_HOLD : CYC_NEXT;
      is_wr = wr_req;
    end
  end
endmodule

// File: rtl/sbsram_wr_dec.sv
module sbsram_wr_dec #(
  parameter int NB = 2
) (
  input  logic          gwr_n,
  input  logic          bwr_n,
  input  logic [NB-1:0] lane_n,
  output logic          wr_req,
  output logic [NB-1:0] lane_we
);
  assign wr_req = ~gwr_n | ~bwr_n;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign lane_we[l] = ~gwr_n | (~bwr_n & ~lane_n[l]);
  end
endmodule

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
  import sbsram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cyc_e       cyc,
  input  logic [1:0] start_lo,
  input  logic       order_il,
  output logic [1:0] lo_now
);
  logic [1:0] base_q, base_d;
  logic [1:0] step_q, step_d;
  logic       ce;
  logic [1:0] step_use;

  always_comb begin
    base_d   = base_q;
    step_d   = step_q;
    ce       = 1'b0;
    step_use = step_q;
    lo_now   = burst_lo(base_q, step_q, order_il);
    unique case (cyc)
      CYC_LOAD: begin
        base_d = start_lo;
        step_d = 2'd0;
        ce     = 1'b1;
        lo_now = start_lo;
      end
      CYC_NEXT: begin
        step_use = step_q + 2'd1;
        step_d   = step_use;
        ce       = 1'b1;
        lo_now   = burst_lo(base_q, step_use, order_il);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= 2'd0;
      step_q <= 2'd0;
    end else if (ce) begin
      base_q <= base_d;
      step_q <= step_d;
    end
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW = 6,
  parameter int LW = 8,
  parameter int NB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [NB-1:0]    lane_we,
  input  logic             rd_en,
  input  logic [NB*LW-1:0] wdata,
  output logic [NB*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [NB*LW-1:0] rd_word;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[l]) mem[addr] <= wdata[l*LW +: LW];
    end
    assign rd_word[l*LW +: LW] = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic             en1_n,
  input  logic             en2,
  input  logic             en3_n,
  input  logic             ads_cpu_n,
  input  logic             ads_ctl_n,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [DW/8-1:0]  lane_n,
  input  logic             order_il,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rd_valid,
  output logic             acc_valid,
  output logic [AW-1:0]    acc_addr
);
  localparam int LW = 8;
  localparam int NB = DW / LW;
  localparam int HW = AW - 2;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          sel_q, sel_d;
  logic [HW-1:0] hi_q, hi_d;
  logic          hi_ce;
  cyc_e          cyc;
  logic          is_wr;
  logic          from_cpu;
  logic          wr_req;
  logic [NB-1:0] lane_dec;
  logic [NB-1:0] lane_we;
  logic [1:0]    lo_now;
  logic [AW-1:0] addr_now;
  logic          access;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sbsram_wr_dec #(.NB(NB)) u_wr_dec (
    .gwr_n   (gwr_n),
    .bwr_n   (bwr_n),
    .lane_n  (lane_n),
    .wr_req  (wr_req),
    .lane_we (lane_dec)
  );

  sbsram_cycle_dec u_cyc_dec (
    .en1_n     (en1_n),
    .en2       (en2),
    .en3_n     (en3_n),
    .ads_cpu_n (ads_cpu_n),
    .ads_ctl_n (ads_ctl_n),
    .adv_n     (adv_n),
    .sel_q     (sel_q),
    .wr_req    (wr_req),
    .cyc       (cyc),
    .is_wr     (is_wr),
    .from_cpu  (from_cpu)
  );

  sbsram_burst_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cyc      (cyc),
    .start_lo (addr_i[1:0]),
    .order_il (order_il),
    .lo_now   (lo_now)
  );

  always_comb begin
    access   = (cyc == CYC_LOAD) || (cyc == CYC_NEXT) || (cyc == CYC_HOLD);
    hi_ce    = (cyc == CYC_LOAD);
    hi_d     = addr_i[AW-1:2];
    addr_now = hi_ce ? addr_i : {hi_q, lo_now};
    lane_we  = (access && is_wr && !from_cpu) ? lane_dec : '0;
    sel_d    = sel_q;
    if (cyc == CYC_LOAD)       sel_d = 1'b1;
    else if (cyc == CYC_DESEL) sel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q     <= 1'b0;
      hi_q      <= '0;
      acc_valid <= 1'b0;
      rd_valid  <= 1'b0;
      acc_addr  <= '0;
    end else begin
      sel_q     <= sel_d;
      if (hi_ce) hi_q <= hi_d;
      acc_valid <= access;
      rd_valid  <= access & ~is_wr;
      if (access) acc_addr <= addr_now;
    end
  end

  sbsram_array #(.AW(AW), .LW(LW), .NB(NB)) u_array (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .addr    (addr_now),
    .lane_we (lane_we),
    .rd_en   (access & ~is_wr),
    .wdata   (wdata),
    .rdata   (rdata)
  );
endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_i,
  input logic          en1_n,
  input logic          en2,
  input logic          en3_n,
  input logic          ads_cpu_n,
  input logic          ads_ctl_n,
  input logic          adv_n,
  input logic          order_il,
  input logic          rd_valid,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr
);
  a_r4_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_cpu_n && !en1_n && en2 && !en3_n) |=> (rd_valid && acc_addr == $past(addr_i)));

  a_r2_disabled_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!en2 && (!ads_ctl_n || (!ads_cpu_n && !en1_n))) |=> !acc_valid);

  a_r3_masked_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en1_n && ads_ctl_n && !acc_valid) |=> !acc_valid);

  a_r7_hold_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_cpu_n && ads_ctl_n && adv_n && acc_valid) |=> (acc_valid && acc_addr == $past(acc_addr)));

  a_r8_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_cpu_n && ads_ctl_n && !adv_n && acc_valid && !order_il) |=>
      (acc_valid && acc_addr[1:0] == ($past(acc_addr[1:0]) + 2'd1)
                 && acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));

  a_r12_read_is_access: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> acc_valid);
endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .en1_n     (en1_n),
  .en2       (en2),
  .en3_n     (en3_n),
  .ads_cpu_n (ads_cpu_n),
  .ads_ctl_n (ads_ctl_n),
  .adv_n     (adv_n),
  .order_il  (order_il),
  .rd_valid  (rd_valid),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr)
);

// File: tb/sbsram_ctrl_tb.sv
`timescale 1ns/1ps
module sbsram_ctrl_tb;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          en1_n, en2, en3_n;
  logic          ads_cpu_n, ads_ctl_n, adv_n;
  logic          gwr_n, bwr_n;
  logic [1:0]    lane_n;
  logic          order_il;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rd_valid, acc_valid;
  logic [AW-1:0] acc_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sbsram_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .en1_n(en1_n), .en2(en2),
    .en3_n(en3_n), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .order_il(order_il),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .acc_valid(acc_valid),
    .acc_addr(acc_addr)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle_in();
    en1_n = 0; en2 = 1; en3_n = 0;
    ads_cpu_n = 1; ads_ctl_n = 1; adv_n = 1;
    gwr_n = 1; bwr_n = 1; lane_n = 2'b11; wdata = '0; addr_i = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
    idle_in();
  endtask

  task automatic wr_all(logic [AW-1:0] a, logic [DW-1:0] d);
    addr_i = a; ads_ctl_n = 0; gwr_n = 0; wdata = d; tick();
  endtask

  task automatic rd_ctl(logic [AW-1:0] a);
    addr_i = a; ads_ctl_n = 0; tick();
  endtask

  task automatic desel();
    ads_ctl_n = 0; en2 = 0; tick();
  endtask

  task automatic beat(bit adv);
    adv_n = ~adv; tick();
  endtask

  task automatic t_reset();
    chk("R1 acc_valid", acc_valid, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 acc_addr", acc_addr, 0);
  endtask

  task automatic t_ctl_write_read();
    wr_all(6'h10, 16'hA55A);
    chk("R5 R12 write acc_valid", acc_valid, 1);
    chk("R5 write rd_valid", rd_valid, 0);
    chk("R5 write addr", acc_addr, 6'h10);
    rd_ctl(6'h10);
    chk("R5 read rd_valid", rd_valid, 1);
    chk("R12 R10 read back", rdata, 16'hA55A);
    desel();
  endtask

  task automatic t_byte_write();
    wr_all(6'h20, 16'h1234);
    addr_i = 6'h20; ads_ctl_n = 0; bwr_n = 0; lane_n = 2'b10; wdata = 16'hFFEE; tick();
    rd_ctl(6'h20);
    chk("R11 lane0 only", rdata, 16'h12EE);
    addr_i = 6'h20; ads_ctl_n = 0; bwr_n = 0; lane_n = 2'b11; wdata = 16'h0000; tick();
    chk("R11 no-lane is write", rd_valid, 0);
    rd_ctl(6'h20);
    chk("R11 no lane written", rdata, 16'h12EE);
    addr_i = 6'h20; ads_ctl_n = 0; gwr_n = 0; bwr_n = 0; lane_n = 2'b11; wdata = 16'h5678; tick();
    rd_ctl(6'h20);
    chk("R10 global overrides lanes", rdata, 16'h5678);
    desel();
  endtask

  task automatic t_cpu_read();
    wr_all(6'h08, 16'hBEEF);
    addr_i = 6'h08; ads_cpu_n = 0; gwr_n = 0; wdata = 16'h0000; tick();
    chk("R4 cpu start reads", rd_valid, 1);
    chk("R4 cpu read data", rdata, 16'hBEEF);
    chk("R4 cpu addr", acc_addr, 6'h08);
    rd_ctl(6'h08);
    chk("R4 array unchanged", rdata, 16'hBEEF);
    desel();
  endtask

  task automatic preload();
    for (int i = 0; i < 4; i++) wr_all(6'h30 + 6'(i), 16'h3000 + 16'(i));
  endtask

  task automatic t_linear();
    logic [1:0] exp_lo [5] = '{2'd2, 2'd3, 2'd0, 2'd1, 2'd2};
    order_il = 0;
    rd_ctl(6'h32);
    chk("R8 start addr", acc_addr, 6'h32);
    for (int i = 1; i < 5; i++) begin
      beat(1);
      chk("R6 R8 linear addr", acc_addr, {4'h C, exp_lo[i]});
      chk("R6 R8 linear data", rdata, 16'h3000 + 16'(exp_lo[i]));
    end
    desel();
  endtask

  task automatic t_interleave();
    logic [1:0] exp_lo [5] = '{2'd1, 2'd0, 2'd3, 2'd2, 2'd1};
    order_il = 1;
    rd_ctl(6'h31);
    chk("R9 start addr", acc_addr, 6'h31);
    for (int i = 1; i < 5; i++) begin
      beat(1);
      chk("R9 interleaved addr", acc_addr, {4'hC, exp_lo[i]});
      chk("R9 interleaved data", rdata, 16'h3000 + 16'(exp_lo[i]));
    end
    desel();
    order_il = 0;
  endtask

  task automatic t_suspend();
    rd_ctl(6'h30);
    beat(1);
    chk("R6 step", acc_addr, 6'h31);
    beat(0);
    chk("R7 hold addr", acc_addr, 6'h31);
    chk("R7 hold reads", rd_valid, 1);
    beat(1);
    chk("R7 resume after hold", acc_addr, 6'h32);
    adv_n = 0; gwr_n = 0; wdata = 16'h7777; tick();
    chk("R6 burst write addr", acc_addr, 6'h33);
    chk("R6 burst write no read", rd_valid, 0);
    rd_ctl(6'h33);
    chk("R6 burst write data", rdata, 16'h7777);
    desel();
  endtask

  task automatic t_deselect();
    rd_ctl(6'h30);
    ads_ctl_n = 0; en2 = 0; addr_i = 6'h05; tick();
    chk("R2 en2 low deselect", acc_valid, 0);
    beat(1);
    chk("R2 no access after deselect", acc_valid, 0);
    ads_cpu_n = 0; en3_n = 1; addr_i = 6'h08; tick();
    chk("R2 en3 high deselect", acc_valid, 0);
  endtask

  task automatic t_mask();
    ads_cpu_n = 0; en1_n = 1; addr_i = 6'h08; tick();
    chk("R3 masked idle", acc_valid, 0);
    rd_ctl(6'h30);
    beat(1);
    ads_cpu_n = 0; en1_n = 1; adv_n = 0; addr_i = 6'h08; tick();
    chk("R3 masked continues burst", acc_addr, 6'h32);
    chk("R3 masked data", rdata, 16'h3002);
    desel();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_in();
    order_il = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1;
    repeat (4) @(posedge clk);
    #2;
    t_reset();
    t_ctl_write_read();
    t_byte_write();
    t_cpu_read();
    preload();
    t_linear();
    t_interleave();
    t_suspend();
    t_deselect();
    t_mask();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule